// File: doc/BRIEF.md
# Edge-Triggered Input Capture Timer

This block is a 16-bit up-counting timer that watches one asynchronous input pin. On the input transitions chosen by a two-bit edge-select field it copies the running count into a capture register. When edge reload is switched on, the same transition also loads the count from a reload register, so the captured value reads directly as the time between edges. Gated counting makes the timer advance only while the input sits at one level, which measures high or low pulse widths. A single-shot request lets the timer run for exactly one edge-to-edge interval while the run enable is low.

A single polarity bit does three jobs. It selects the level at which gated counting advances. In both-edge mode, when gating or a single-shot is active, it selects which edge captures without reloading. It also selects which edge starts and stops a single-shot run. The capture flag and the overflow flag stay set until software clears them, and the interrupt request combines both flags with an enable. The block drives no output waveform.

Top module: `cap_timer`

## Requirements
- R1: After reset, count, capture_val, cap_flag, ovf_flag, oneshot_busy and irq are all zero.
- R2: edge_sel selects the capturing edges of the synchronized pin: 2'b01 selects rising, 2'b10 selects falling, 2'b11 selects both, and 2'b00 selects none. With 2'b00, capture_val and cap_flag never change.
- R3: When reload_on_edge is 1, a capturing edge copies count into capture_val and loads count from reload_val in the same cycle. The reload takes priority over that cycle's increment.
- R4: When gate_en is 1, count advances only while the synchronized pin is high (pol=0) or low (pol=1).
- R5: With edge_sel=2'b11, reload_on_edge=1 and gate_en=1, the falling edge (pol=0) or the rising edge (pol=1) captures without reloading.
- R6: A pulse on oneshot_req arms a single-shot run (oneshot_busy=1) that works while run_en=0. The starting edge may capture and reload but does not set cap_flag. The next defined edge captures, sets cap_flag, stops the count and clears oneshot_busy.
- R7: In a single-shot run with edge_sel=2'b11, the rising edge (pol=0) or the falling edge (pol=1) starts and stops the run. The opposite edge captures but does not reload. Edges seen while the run is armed but not started are ignored.
- R8: When count would roll over from FFFFh, it loads reload_val instead and ovf_flag is set.
- R9: cap_flag and ovf_flag stay set until clr_cap_flag or clr_ovf_flag is asserted. irq equals irq_en AND (cap_flag OR ovf_flag).
- R10: With run_en=0 and no single-shot in progress, count holds and no capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Free-run enable |
| edge_sel | input | 2 | Capturing edge select |
| reload_on_edge | input | 1 | Also reload count on capturing edges |
| gate_en | input | 1 | Gate counting by pin level |
| pol | input | 1 | Gate level, no-reload edge, single-shot edge |
| oneshot_req | input | 1 | Pulse to arm a single-shot run |
| irq_en | input | 1 | Interrupt enable |
| reload_val | input | 16 | Reload value |
| pin_in | input | 1 | Asynchronous input pin |
| clr_cap_flag | input | 1 | Clear capture flag |
| clr_ovf_flag | input | 1 | Clear overflow flag |
| count | output | 16 | Current timer value |
| capture_val | output | 16 | Last captured value |
| cap_flag | output | 1 | Sticky capture flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| oneshot_busy | output | 1 | Single-shot armed or running |
| irq | output | 1 | Interrupt request |

## Verification
The checker tests several properties on every cycle:
- sticky flags hold until their clear is asserted;
- irq is never raised without a set flag and the enable;
- capture_val is frozen while no edge is selected;
- count holds while stopped;
- an overflow leaves count at the reload value;
- a single-shot run always ends with cap_flag set.

Other behaviours need the bench's pin waveforms, because they depend on edge spacing over many cycles. These are the captured interval values under each edge select, the gating polarity, the no-reload edge in gated both-edge mode, and the start and stop edges of single-shot runs.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    SS_IDLE  = 2'b00,
    SS_ARMED = 2'b01,
    SS_RUN   = 2'b10
  } ss_state_e;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/cap_in_sync.sv
module cap_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
  assign fall  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cap_oneshot_ctrl.sv
module cap_oneshot_ctrl
  import cap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oneshot_req,
  input  logic       gate_en,
  input  logic       pol,
  input  logic [1:0] edge_sel,
  input  logic       rise,
  input  logic       fall,
  input  logic       edge_hit,
  output logic       ss_busy,
  output logic       ss_running,
  output logic       ss_start,
  output logic       ss_stop
);
  ss_state_e state_q, state_d;
  logic      both_mode, key_edge, gate_open_edge, start_trig, stop_trig;

  always_comb begin
    both_mode      = (edge_sel == EDGE_BOTH);
    key_edge       = pol ? fall : rise;
    gate_open_edge = pol ? fall : rise;
    start_trig     = gate_en ? gate_open_edge : (both_mode ? key_edge : edge_hit);
    stop_trig      = both_mode ? key_edge : edge_hit;
    ss_start       = (state_q == SS_ARMED) & start_trig;
    ss_stop        = (state_q == SS_RUN) & stop_trig;
    state_d        = state_q;
    unique case (state_q)
      SS_IDLE:  if (oneshot_req) state_d = SS_ARMED;
      SS_ARMED: if (ss_start)    state_d = SS_RUN;
      SS_RUN:   if (ss_stop)     state_d = SS_IDLE;
      default:                   state_d = SS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SS_IDLE;
    else        state_q <= state_d;
  end

  assign ss_busy    = (state_q != SS_IDLE);
  assign ss_running = (state_q == SS_RUN);
endmodule

// File: rtl/cap_count_core.sv
module cap_count_core
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             ss_busy,
  input  logic             ss_running,
  input  logic             ss_start,
  input  logic             ss_stop,
  input  logic             gate_en,
  input  logic             pol,
  input  logic [1:0]       edge_sel,
  input  logic             reload_on_edge,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  input  logic             edge_hit,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             clr_cap,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture_val,
  output logic             cap_flag,
  output logic             ovf_flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic             capf_q, capf_d, ovff_q, ovff_d;
  logic             active, gate_ok, cnt_en, no_reload, do_cap, do_reload, wrap;

  always_comb begin
    active    = run_en | ss_running;
    gate_ok   = ~gate_en | (level == ~pol);
    cnt_en    = active & gate_ok & ~ss_stop;
    no_reload = (edge_sel == EDGE_BOTH) & (gate_en | ss_busy) & (pol ? rise : fall);
    do_cap    = edge_hit & (active | ss_start);
    do_reload = do_cap & reload_on_edge & ~no_reload;
    wrap      = cnt_en & (cnt_q == {CNT_W{1'b1}});

    if (do_reload)   cnt_d = reload_val;
    else if (wrap)   cnt_d = reload_val;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;

    cap_d  = do_cap ? cnt_q : cap_q;
    capf_d = (do_cap & ~ss_start) | (capf_q & ~clr_cap);
    ovff_d = (wrap & ~do_reload) | (ovff_q & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      capf_q <= 1'b0;
      ovff_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      capf_q <= capf_d;
      ovff_q <= ovff_d;
    end
  end

  assign count       = cnt_q;
  assign capture_val = cap_q;
  assign cap_flag    = capf_q;
  assign ovf_flag    = ovff_q;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       edge_sel,
  input  logic             reload_on_edge,
  input  logic             gate_en,
  input  logic             pol,
  input  logic             oneshot_req,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             pin_in,
  input  logic             clr_cap_flag,
  input  logic             clr_ovf_flag,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture_val,
  output logic             cap_flag,
  output logic             ovf_flag,
  output logic             oneshot_busy,
  output logic             irq
);
  logic level, rise, fall, edge_hit;
  logic ss_busy, ss_running, ss_start, ss_stop;

  cap_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .level(level), .rise(rise), .fall(fall)
  );

  assign edge_hit = (rise & edge_sel[0]) | (fall & edge_sel[1]);

  cap_oneshot_ctrl u_ss (
    .clk(clk), .rst_n(rst_n), .oneshot_req(oneshot_req), .gate_en(gate_en),
    .pol(pol), .edge_sel(edge_sel), .rise(rise), .fall(fall), .edge_hit(edge_hit),
    .ss_busy(ss_busy), .ss_running(ss_running), .ss_start(ss_start), .ss_stop(ss_stop)
  );

  cap_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ss_busy(ss_busy),
    .ss_running(ss_running), .ss_start(ss_start), .ss_stop(ss_stop),
    .gate_en(gate_en), .pol(pol), .edge_sel(edge_sel),
    .reload_on_edge(reload_on_edge), .level(level), .rise(rise), .fall(fall),
    .edge_hit(edge_hit), .reload_val(reload_val), .clr_cap(clr_cap_flag),
    .clr_ovf(clr_ovf_flag), .count(count), .capture_val(capture_val),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag)
  );

  assign oneshot_busy = ss_busy;
  assign irq          = irq_en & (cap_flag | ovf_flag);
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic [1:0]       edge_sel,
  input logic             irq_en,
  input logic [CNT_W-1:0] reload_val,
  input logic             clr_cap_flag,
  input logic             clr_ovf_flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture_val,
  input logic             cap_flag,
  input logic             ovf_flag,
  input logic             oneshot_busy,
  input logic             irq
);
  assert_no_edge_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |=> $stable(capture_val));

  assert_overflow_reloads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && $stable(reload_val)) |-> (count == reload_val));

  assert_cap_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !clr_cap_flag) |=> cap_flag);

  assert_ovf_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf_flag) |=> ovf_flag);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (cap_flag || ovf_flag)));

  assert_stopped_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !oneshot_busy) |=> $stable(count));

  assert_oneshot_end_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oneshot_busy) |-> cap_flag);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .edge_sel(edge_sel),
  .irq_en(irq_en), .reload_val(reload_val), .clr_cap_flag(clr_cap_flag),
  .clr_ovf_flag(clr_ovf_flag), .count(count), .capture_val(capture_val),
  .cap_flag(cap_flag), .ovf_flag(ovf_flag), .oneshot_busy(oneshot_busy),
  .irq(irq)
);

// File: tb/tb_cap_timer.sv
module tb_cap_timer;
  logic        clk, rst_n, run_en, reload_on_edge, gate_en, pol, oneshot_req;
  logic        irq_en, pin_in, clr_cap_flag, clr_ovf_flag;
  logic [1:0]  edge_sel;
  logic [15:0] reload_val, count, capture_val;
  logic        cap_flag, ovf_flag, oneshot_busy, irq;
  int          checks, failures;

  cap_timer dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .edge_sel(edge_sel),
    .reload_on_edge(reload_on_edge), .gate_en(gate_en), .pol(pol),
    .oneshot_req(oneshot_req), .irq_en(irq_en), .reload_val(reload_val),
    .pin_in(pin_in), .clr_cap_flag(clr_cap_flag), .clr_ovf_flag(clr_ovf_flag),
    .count(count), .capture_val(capture_val), .cap_flag(cap_flag),
    .ovf_flag(ovf_flag), .oneshot_busy(oneshot_busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {edge_sel, pol, gate_en, high cycles, low cycles, reload, expected capture}
  localparam int NV = 7;
  localparam logic [51:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b0, 8'd5, 8'd7, 16'h0100, 16'h010B},  // R2 R3 rising
    {2'b10, 1'b0, 1'b0, 8'd4, 8'd6, 16'h0200, 16'h0209},  // R2 R3 falling
    {2'b11, 1'b0, 1'b0, 8'd6, 8'd4, 16'h0300, 16'h0305},  // R2 R3 both
    {2'b10, 1'b0, 1'b1, 8'd5, 8'd6, 16'h0400, 16'h0405},  // R4 high width
    {2'b01, 1'b1, 1'b1, 8'd4, 8'd7, 16'h0500, 16'h0507},  // R4 low width
    {2'b11, 1'b0, 1'b1, 8'd8, 8'd3, 16'h0600, 16'h0607},  // R5 pol 0
    {2'b11, 1'b1, 1'b1, 8'd4, 8'd5, 16'h0700, 16'h0704}   // R5 pol 1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pin_in = 1'b0;
    oneshot_req = 1'b0;
    clr_cap_flag = 1'b0;
    clr_ovf_flag = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_in = 1'b1;
    repeat (hi) @(negedge clk);
    pin_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    run_en = 1'b0; edge_sel = 2'b00; reload_on_edge = 1'b0; gate_en = 1'b0;
    pol = 1'b0; irq_en = 1'b1; reload_val = 16'h0;
    do_reset();
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 capture", capture_val, 0);
    chk("R1 flags", {cap_flag, ovf_flag, oneshot_busy, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      edge_sel = VEC[i][51:50]; pol = VEC[i][49]; gate_en = VEC[i][48];
      reload_val = VEC[i][31:16]; reload_on_edge = 1'b1; run_en = 1'b1;
      do_reset();
      repeat (3) pulse(int'(VEC[i][47:40]), int'(VEC[i][39:32]));
      repeat (5) @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 vector %0d capture", i), capture_val, VEC[i][15:0]);
      chk($sformatf("R2 vector %0d cap_flag", i), cap_flag, 1);
    end

    // R2: no edge selected
    edge_sel = 2'b00; gate_en = 1'b0; pol = 1'b0; run_en = 1'b1;
    do_reset();
    repeat (3) pulse(4, 4);
    repeat (5) @(negedge clk);
    chk("R2 none capture", capture_val, 0);
    chk("R2 none flag", cap_flag, 0);

    // R10: stopped timer
    edge_sel = 2'b01; run_en = 1'b0;
    do_reset();
    repeat (3) pulse(4, 4);
    repeat (5) @(negedge clk);
    chk("R10 count held", count, 0);
    chk("R10 no capture", {capture_val, cap_flag}, 0);

    // R8 and R9: overflow, irq, clears
    edge_sel = 2'b01; run_en = 1'b1; reload_val = 16'hFFF0; irq_en = 1'b0;
    do_reset();
    pin_in = 1'b1;
    repeat (4) @(negedge clk);
    edge_sel = 2'b00;
    repeat (25) @(negedge clk);
    chk("R8 ovf_flag", ovf_flag, 1);
    chk("R8 count reloaded", count >= 16'hFFF0, 1);
    chk("R9 irq disabled", irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R9 irq enabled", irq, 1);
    clr_ovf_flag = 1'b1; clr_cap_flag = 1'b1;
    @(negedge clk);
    clr_ovf_flag = 1'b0; clr_cap_flag = 1'b0; run_en = 1'b0;
    @(negedge clk);
    chk("R9 cleared", {cap_flag, ovf_flag, irq}, 0);

    // R6: single-shot on rising edges
    edge_sel = 2'b01; run_en = 1'b0; reload_val = 16'h0800; pol = 1'b0;
    do_reset();
    oneshot_req = 1'b1;
    @(negedge clk);
    oneshot_req = 1'b0;
    chk("R6 armed", oneshot_busy, 1);
    pin_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 start no flag", cap_flag, 0);
    repeat (1) @(negedge clk);
    pin_in = 1'b0;
    repeat (5) @(negedge clk);
    pulse(6, 0);
    chk("R6 capture", capture_val, 16'h0809);
    chk("R6 end", {cap_flag, oneshot_busy}, 2'b10);
    repeat (8) @(negedge clk);
    chk("R6 stopped", count, 16'h0800);

    // R7: single-shot both edges, falling start/stop
    edge_sel = 2'b11; pol = 1'b1; reload_val = 16'h0900;
    do_reset();
    oneshot_req = 1'b1;
    @(negedge clk);
    oneshot_req = 1'b0;
    pulse(4, 6);
    pin_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 opposite edge capture", capture_val, 16'h0905);
    chk("R7 mid run", {cap_flag, oneshot_busy}, 2'b11);
    pin_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 final capture", capture_val, 16'h0909);
    chk("R7 done", oneshot_busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule